// File: doc/BRIEF.md
# Load/Store Address Generation Unit

This unit turns the operand fields of a load or store into the memory address that the access uses. It takes a base value, which may be a general register or the program counter, together with a second register value used as an index, a 12-bit signed immediate, an addressing-mode code, an add/subtract select and a small left-shift amount for the index. From these it forms the effective address. When the mode updates the base register, it also forms a new base value and raises a writeback strobe.

A single add/subtract datapath serves every mode. The modes cover plain register-indirect access, base plus immediate, base plus or minus a register, base plus or minus a left-shifted register index, and the two base-updating forms. In the pre-indexed form the address is the offset sum, and that sum also goes back to the base. In the post-indexed form the untouched base is the address, and the offset sum goes back to the base afterwards.

All arithmetic wraps modulo 2^32. With the default parameter `OUT_REG = 1`, the three results are registered and appear one clock after their inputs. The register file, the memory port and any literal-fetch sequencing sit outside this block.

Top module: `ls_addr_gen`

## Requirements
- R1: Mode code 0 (indirect) drives the address with the base value unchanged. The writeback strobe stays low and the new-base output equals the base.
- R2: Mode code 1 (immediate) drives the address with base plus the 12-bit immediate, which is sign-extended from bit 11. For example, 0xFFF adds -1 and 0x800 adds -2048. The add/subtract select has no effect in this mode.
- R3: Mode code 2 (register) gives base plus index when the subtract select is 0 and base minus index when it is 1. The shift amount has no effect in this mode.
- R4: Mode code 3 (scaled) shifts the index left by the shift amount (0 to 3) before it is added to or subtracted from the base. A shift of 2 multiplies the index by 4.
- R5: Mode codes 4 (pre-indexed immediate) and 6 (pre-indexed register, shifted and signed as in R4) drive the address with the base-plus-offset sum. With the writeback request high, the strobe is high and the new base equals that sum. With the request low, the strobe is low and the new base equals the base.
- R6: Mode codes 5 (post-indexed immediate) and 7 (post-indexed register, shifted and signed as in R4) drive the address with the unmodified base. In these modes the strobe is always high and the new base equals the base-plus-offset sum, whatever the writeback request is.
- R7: The writeback strobe is high only in mode codes 4 to 7. In mode codes 0 to 3 the new-base output equals the base.
- R8: Every sum and difference wraps modulo 2^32, and any carry or borrow out of bit 31 is discarded.
- R9: With OUT_REG = 1, all outputs reflect the inputs sampled at the previous rising clock edge. While the active-low reset is asserted, the address, the new base and the strobe are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| base_i | input | 32 | Base value (register or program counter) |
| index_i | input | 32 | Index register value |
| imm_i | input | 12 | Signed immediate offset |
| mode_i | input | 3 | Addressing-mode code 0 to 7 |
| sub_i | input | 1 | 1 subtracts the register offset, 0 adds it |
| shift_i | input | 2 | Left shift applied to the index in scaled forms |
| wb_req_i | input | 1 | Writeback request for the pre-indexed forms |
| addr_o | output | 32 | Effective address |
| new_base_o | output | 32 | Value to write back to the base register |
| wb_en_o | output | 1 | Base writeback strobe |

## Verification
The address, the new base and the strobe all come from one register stage, so every result is due exactly one rising edge after the inputs that produce it. The driver changes inputs on the falling edge and queues the expected triple at the same moment. The monitor pops and compares one entry a short delay after each following rising edge. Because inputs change every cycle, each comparison holds only if the latency is exactly one edge. Reset values are sampled while reset is held, before any entry has been queued.

// File: rtl/lsagu_pkg.sv
package lsagu_pkg;

   typedef enum logic [2:0] {
      AM_BASE     = 3'd0,
      AM_IMM      = 3'd1,
      AM_REG      = 3'd2,
      AM_SCALED   = 3'd3,
      AM_PRE_IMM  = 3'd4,
      AM_POST_IMM = 3'd5,
      AM_PRE_REG  = 3'd6,
      AM_POST_REG = 3'd7
   } amode_e;

   // base-updating forms
   function automatic logic am_updates(amode_e m);
      return (m == AM_PRE_IMM) || (m == AM_POST_IMM) ||
             (m == AM_PRE_REG) || (m == AM_POST_REG);
   endfunction

   function automatic logic am_post(amode_e m);
      return (m == AM_POST_IMM) || (m == AM_POST_REG);
   endfunction

   function automatic logic am_pre(amode_e m);
      return (m == AM_PRE_IMM) || (m == AM_PRE_REG);
   endfunction

endpackage

// File: rtl/lsagu_offset.sv
module lsagu_offset
   import lsagu_pkg::*;
#(
   parameter int AW    = 32,
   parameter int IMM_W = 12,
   parameter int SHW   = 2
) (
   input  amode_e          mode,
   input  logic [AW-1:0]   index,
   input  logic [IMM_W-1:0] imm,
   input  logic            sub,
   input  logic [SHW-1:0]  shift,
   output logic [AW-1:0]   off,
   output logic            neg
);
   localparam int EXT_W = AW - IMM_W;

   logic [AW-1:0] imm_ext;
   logic [AW-1:0] stg [SHW+1];

   assign imm_ext = {{EXT_W{imm[IMM_W-1]}}, imm};

   // logarithmic left shifter, one stage per shift bit
   assign stg[0] = index;
   for (genvar g = 0; g < SHW; g++) begin : g_shstage
      localparam int DIST = 1 << g;
      assign stg[g+1] = shift[g] ? (stg[g] << DIST) : stg[g];
   end

   always_comb begin
      off = '0;
      neg = 1'b0;
      unique case (mode)
         AM_BASE: begin
            off = '0;
            neg = 1'b0;
         end
         AM_IMM, AM_PRE_IMM, AM_POST_IMM: begin
            off = imm_ext;
            neg = 1'b0;
         end
         AM_REG: begin
            off = index;
            neg = sub;
         end
         AM_SCALED, AM_PRE_REG, AM_POST_REG: begin
            off = stg[SHW];
            neg = sub;
         end
         default: begin
            off = '0;
            neg = 1'b0;
         end
      endcase
   end

endmodule

// File: rtl/lsagu_sum.sv
module lsagu_sum #(
   parameter int AW = 32
) (
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] off,
   input  logic          neg,
   output logic [AW-1:0] sum
);
   logic [AW-1:0] operand;
   logic [AW-1:0] carry_in;

   // two's complement subtract: invert and add one, wrap modulo 2^AW
   assign operand  = neg ? ~off : off;
   assign carry_in = {{(AW-1){1'b0}}, neg};
   assign sum      = base + operand + carry_in;

endmodule

// File: rtl/lsagu_route.sv
module lsagu_route
   import lsagu_pkg::*;
#(
   parameter int AW = 32
) (
   input  amode_e        mode,
   input  logic          wb_req,
   input  logic [AW-1:0] base,
   input  logic [AW-1:0] sum,
   output logic [AW-1:0] addr,
   output logic [AW-1:0] nbase,
   output logic          wb
);
   always_comb begin
      addr  = sum;
      nbase = base;
      wb    = 1'b0;
      unique case (mode)
         AM_BASE: begin
            addr = base;
         end
         AM_IMM, AM_REG, AM_SCALED: begin
            addr = sum;
         end
         AM_PRE_IMM, AM_PRE_REG: begin
            addr = sum;
            if (wb_req) begin
               wb    = 1'b1;
               nbase = sum;
            end
         end
         AM_POST_IMM, AM_POST_REG: begin
            addr  = base;
            wb    = 1'b1;
            nbase = sum;
         end
         default: begin
            addr = base;
         end
      endcase
   end

endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import lsagu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int IMM_W   = 12,
   parameter int SHW     = 2,
   parameter bit OUT_REG = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [AW-1:0]    base_i,
   input  logic [AW-1:0]    index_i,
   input  logic [IMM_W-1:0] imm_i,
   input  logic [2:0]       mode_i,
   input  logic             sub_i,
   input  logic [SHW-1:0]   shift_i,
   input  logic             wb_req_i,
   output logic [AW-1:0]    addr_o,
   output logic [AW-1:0]    new_base_o,
   output logic             wb_en_o
);
   localparam int MAX_SH = (1 << SHW) - 1;

   if (IMM_W >= AW) begin : g_bad_imm
      $error("ls_addr_gen: IMM_W must be narrower than AW");
   end
   if (SHW < 1 || MAX_SH >= AW) begin : g_bad_shw
      $error("ls_addr_gen: SHW out of range for AW");
   end

   amode_e        mode;
   logic [AW-1:0] off;
   logic          neg;
   logic [AW-1:0] sum;
   logic [AW-1:0] addr_c;
   logic [AW-1:0] nbase_c;
   logic          wb_c;

   assign mode = amode_e'(mode_i);

   lsagu_offset #(.AW(AW), .IMM_W(IMM_W), .SHW(SHW)) u_off (
      .mode  (mode),
      .index (index_i),
      .imm   (imm_i),
      .sub   (sub_i),
      .shift (shift_i),
      .off   (off),
      .neg   (neg)
   );

   lsagu_sum #(.AW(AW)) u_sum (
      .base (base_i),
      .off  (off),
      .neg  (neg),
      .sum  (sum)
   );

   lsagu_route #(.AW(AW)) u_route (
      .mode   (mode),
      .wb_req (wb_req_i),
      .base   (base_i),
      .sum    (sum),
      .addr   (addr_c),
      .nbase  (nbase_c),
      .wb     (wb_c)
   );

   if (OUT_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            addr_o     <= '0;
            new_base_o <= '0;
            wb_en_o    <= 1'b0;
         end else begin
            addr_o     <= addr_c;
            new_base_o <= nbase_c;
            wb_en_o    <= wb_c;
         end
      end
   end else begin : g_comb
      assign addr_o     = rst_n ? addr_c  : '0;
      assign new_base_o = rst_n ? nbase_c : '0;
      assign wb_en_o    = rst_n & wb_c;
   end

endmodule

// File: rtl/lsagu_chk.sv
module lsagu_chk
   import lsagu_pkg::*;
#(
   parameter int AW      = 32,
   parameter int IMM_W   = 12,
   parameter bit OUT_REG = 1'b1
) (
   input logic             clk,
   input logic             rst_n,
   input logic [AW-1:0]    base_i,
   input logic [IMM_W-1:0] imm_i,
   input logic [2:0]       mode_i,
   input logic             wb_req_i,
   input logic [AW-1:0]    addr_o,
   input logic [AW-1:0]    new_base_o,
   input logic             wb_en_o
);
   logic [AW-1:0]    r_base;
   logic [IMM_W-1:0] r_imm;
   amode_e           r_mode;
   logic             r_wbreq;
   logic             primed;

   if (OUT_REG) begin : g_lag
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            r_base  <= '0;
            r_imm   <= '0;
            r_mode  <= AM_BASE;
            r_wbreq <= 1'b0;
            primed  <= 1'b0;
         end else begin
            r_base  <= base_i;
            r_imm   <= imm_i;
            r_mode  <= amode_e'(mode_i);
            r_wbreq <= wb_req_i;
            primed  <= 1'b1;
         end
      end
   end else begin : g_now
      assign r_base  = base_i;
      assign r_imm   = imm_i;
      assign r_mode  = amode_e'(mode_i);
      assign r_wbreq = wb_req_i;
      assign primed  = 1'b1;
   end

   logic [AW-1:0] r_imm_ext;
   assign r_imm_ext = {{(AW-IMM_W){r_imm[IMM_W-1]}}, r_imm};

   assert_indirect_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && r_mode == AM_BASE) |-> (addr_o == r_base && !wb_en_o));

   assert_imm_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && r_mode == AM_IMM) |-> (addr_o == r_base + r_imm_ext));

   assert_pre_wb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && am_pre(r_mode) && r_wbreq) |-> (wb_en_o && addr_o == new_base_o));

   assert_pre_nowb_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && am_pre(r_mode) && !r_wbreq) |-> (!wb_en_o && new_base_o == r_base));

   assert_post_addr_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && am_post(r_mode)) |-> (wb_en_o && addr_o == r_base));

   assert_wb_modes_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && wb_en_o) |-> am_updates(r_mode));

   assert_base_kept_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (primed && !am_updates(r_mode)) |-> (new_base_o == r_base));

endmodule

bind ls_addr_gen lsagu_chk #(.AW(AW), .IMM_W(IMM_W), .OUT_REG(OUT_REG)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .base_i     (base_i),
   .imm_i      (imm_i),
   .mode_i     (mode_i),
   .wb_req_i   (wb_req_i),
   .addr_o     (addr_o),
   .new_base_o (new_base_o),
   .wb_en_o    (wb_en_o)
);

// File: tb/sim_ls_addr_gen.sv
`timescale 1ns/1ps
module sim_ls_addr_gen;

   typedef struct {
      logic [31:0] addr;
      logic [31:0] nb;
      logic        wb;
      string       tag;
   } exp_t;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [31:0] base_i = '0;
   logic [31:0] index_i = '0;
   logic [11:0] imm_i = '0;
   logic [2:0]  mode_i = '0;
   logic        sub_i = 1'b0;
   logic [1:0]  shift_i = '0;
   logic        wb_req_i = 1'b0;
   logic [31:0] addr_o;
   logic [31:0] new_base_o;
   logic        wb_en_o;

   int checks = 0;
   int fails  = 0;
   bit done   = 1'b0;
   exp_t q[$];

   always #2.5 clk = ~clk;

   ls_addr_gen u0 (
      .clk(clk), .rst_n(rst_n), .base_i(base_i), .index_i(index_i),
      .imm_i(imm_i), .mode_i(mode_i), .sub_i(sub_i), .shift_i(shift_i),
      .wb_req_i(wb_req_i), .addr_o(addr_o), .new_base_o(new_base_o),
      .wb_en_o(wb_en_o)
   );

   function automatic exp_t model(logic [31:0] b, logic [31:0] x, logic [11:0] im,
                                  logic [2:0] m, logic s, logic [1:0] sh, logic wr,
                                  string tag);
      exp_t e;
      logic [31:0] simm, roff, total;
      simm  = {{20{im[11]}}, im};
      roff  = (m == 3'd2) ? x : (x << sh);
      total = (m == 3'd0) ? b :
              (m == 3'd1 || m == 3'd4 || m == 3'd5) ? b + simm :
              (s ? b - roff : b + roff);
      e.tag  = tag;
      e.addr = (m == 3'd0 || m == 3'd5 || m == 3'd7) ? b : total;
      e.wb   = (m == 3'd5 || m == 3'd7) || ((m == 3'd4 || m == 3'd6) && wr);
      e.nb   = e.wb ? total : b;
      return e;
   endfunction

   task automatic check(string tag, logic [31:0] a, logic [31:0] ea,
                        logic [31:0] n, logic [31:0] en, logic w, logic ew);
      checks++;
      if (a !== ea || n !== en || w !== ew) begin
         fails++;
         $display("FAIL %s: addr=%h new_base=%h wb=%b expected addr=%h new_base=%h wb=%b",
                  tag, a, n, w, ea, en, ew);
      end
   endtask

   task automatic drive(logic [31:0] b, logic [31:0] x, logic [11:0] im, logic [2:0] m,
                        logic s, logic [1:0] sh, logic wr, string tag);
      @(negedge clk);
      base_i = b; index_i = x; imm_i = im; mode_i = m;
      sub_i = s; shift_i = sh; wb_req_i = wr;
      q.push_back(model(b, x, im, m, s, sh, wr, tag));
   endtask

   // monitor: results are due one rising edge after the drive
   always @(posedge clk) begin
      #1;
      if (rst_n && q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         check(e.tag, addr_o, e.addr, new_base_o, e.nb, wb_en_o, e.wb);
      end
   end

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   endtask

   initial begin
      #100000;
      checks++;
      fails++;
      $display("FAIL watchdog: run hung, expected completion");
      finish_run();
   end

   initial begin
      // R9: reset state while inputs are busy
      base_i = 32'hDEAD_BEEF; mode_i = 3'd5; imm_i = 12'h010;
      repeat (3) @(negedge clk);
      check("R9 reset", addr_o, 32'h0, new_base_o, 32'h0, wb_en_o, 1'b0);
      rst_n = 1'b1;
      @(negedge clk);

      drive(32'h2000_0004, 32'h0000_0010, 12'h004, 3'd0, 1'b1, 2'd3, 1'b1, "R1 indirect");
      drive(32'h2000_0000, 32'h0,         12'h004, 3'd1, 1'b0, 2'd0, 1'b0, "R2 imm pos");
      drive(32'h2000_0008, 32'h0,         12'hFFC, 3'd1, 1'b0, 2'd0, 1'b0, "R2 imm -4");
      drive(32'h2000_0000, 32'h0,         12'h800, 3'd1, 1'b0, 2'd0, 1'b0, "R2 imm min");
      drive(32'h2000_0000, 32'h0,         12'h7FF, 3'd1, 1'b1, 2'd2, 1'b0, "R2 sub ignored");
      drive(32'h2000_0100, 32'h0000_0020, 12'h000, 3'd2, 1'b0, 2'd0, 1'b0, "R3 reg add");
      drive(32'h2000_0100, 32'h0000_0020, 12'h000, 3'd2, 1'b1, 2'd0, 1'b0, "R3 reg sub");
      drive(32'h2000_0100, 32'h0000_0020, 12'h000, 3'd2, 1'b0, 2'd3, 1'b1, "R3 shift ignored");
      drive(32'h2000_0000, 32'h0000_0003, 12'h000, 3'd3, 1'b0, 2'd2, 1'b0, "R4 scaled x4");
      drive(32'h2000_0100, 32'h0000_0005, 12'h000, 3'd3, 1'b1, 2'd3, 1'b0, "R4 scaled sub x8");
      drive(32'h2000_0000, 32'h0000_0007, 12'h000, 3'd3, 1'b0, 2'd0, 1'b0, "R4 scaled x1");
      drive(32'h2000_0000, 32'h0,         12'h004, 3'd4, 1'b0, 2'd0, 1'b1, "R5 pre imm wb");
      drive(32'h2000_0000, 32'h0,         12'h004, 3'd4, 1'b0, 2'd0, 1'b0, "R5 pre imm no wb");
      drive(32'h2000_0040, 32'h0000_0004, 12'h000, 3'd6, 1'b1, 2'd1, 1'b1, "R5 pre reg sub");
      drive(32'h2000_0000, 32'h0,         12'h008, 3'd5, 1'b0, 2'd0, 1'b0, "R6 post imm");
      drive(32'h2000_0010, 32'h0000_0002, 12'h000, 3'd7, 1'b1, 2'd2, 1'b1, "R6 post reg sub");
      drive(32'h2000_0010, 32'h0000_0001, 12'hFFF, 3'd3, 1'b0, 2'd1, 1'b1, "R7 no wb mode3");
      drive(32'h2000_0010, 32'h0000_0001, 12'h001, 3'd1, 1'b0, 2'd0, 1'b1, "R7 no wb mode1");
      drive(32'hFFFF_FFFC, 32'h0000_0008, 12'h000, 3'd2, 1'b0, 2'd0, 1'b0, "R8 wrap add");
      drive(32'h0000_0002, 32'h0000_0001, 12'h000, 3'd3, 1'b1, 2'd2, 1'b0, "R8 wrap sub");
      drive(32'h0000_0000, 32'h0,         12'hFFF, 3'd5, 1'b0, 2'd0, 1'b0, "R8 wrap post");
      drive(32'h1234_5678, 32'h0,         12'h000, 3'd0, 1'b0, 2'd0, 1'b0, "R9 latency");

      repeat (3) @(negedge clk);
      if (q.size() != 0) begin
         checks++;
         fails++;
         $display("FAIL R9: %0d results missing, expected 0", q.size());
      end
      finish_run();
   end

endmodule